// File: doc/BRIEF.md
# Byte Serializer/Deserializer with Facility and Equipment Loopback

This block is the digital core of a byte-wide line transceiver. On the transmit side a parallel byte is turned into a serial bit stream, most significant bit first, one bit per rising edge of the transmit bit clock. On the receive side a serial stream is gathered eight bits at a time into a parallel byte. A low-speed receive clock at one eighth of the bit rate frames each received byte. The bit clocks are plain digital clock inputs. Clock synthesis, clock recovery, byte alignment and line coding belong to neighbouring blocks.

Two loopback controls reroute the serial paths while the normal outputs keep running. Facility loopback sends the line receive data straight back out on the serial transmit output, and the receiver still deserializes it. Equipment loopback feeds the serializer's own bit stream into the deserializer and clocks the receiver from the transmit bit clock. A signal-detect input from the optics, of either polarity, is turned into one synchronized loss-of-signal flag.

The serializer is a two-state machine. SER_LOAD takes a new byte and goes to SER_SHIFT. SER_SHIFT shifts one bit per edge and returns to SER_LOAD after the eighth bit. The deserializer is also a two-state machine. DES_FILL holds the valid flag low until the first byte is complete, then goes to DES_RUN. DES_RUN stays there and delivers one byte every eight bit times. A combinational decoder turns the two loopback controls into one of four path modes: PM_NORMAL, PM_FACILITY, PM_EQUIPMENT and PM_DUAL.

Top module: `sds_transceiver`

## Requirements
- R1: `tx_ser_out` carries the serializer's bit, MSB first, in normal and equipment modes. `tx_byte` is sampled at the first `tx_bit_clk` edge after reset release and then at every eighth edge. Bit b of the n-th sampled byte (n from 0) drives `tx_ser_out` after edge 8n+8-b.
- R2: The deserializer samples its input on every rising edge of the receive core clock. The earliest of eight samples lands in `rx_byte[7]`. After edge 8m (m from 1, counted from reset release) `rx_byte` shows samples 8m-7 through 8m.
- R3: `rx_byte_valid` is 0 from reset until edge 8 and is 1 from then on. `rx_byte` does not change between byte updates.
- R4: `rx_ls_clk` is a registered divide-by-8 of the receive core clock. It is 1 after edges whose count modulo 8 is 4 to 7 and 0 otherwise, so it falls at the same edge that updates `rx_byte`.
- R5: With `fac_loop`=1 and `eq_loop`=0, `tx_ser_out` equals `rx_ser_in` combinationally. The receiver still deserializes `rx_ser_in` on `rx_bit_clk` as in R2.
- R6: With `eq_loop`=1, the deserializer takes the serializer's registered bit instead of `rx_ser_in`. Sample k is therefore the bit `tx_ser_out` held after edge k-1, with 0 before the first edge. With `fac_loop`=0, `tx_ser_out` still carries the serialized bytes.
- R7: With `eq_loop`=1, the receiver, `rx_ls_clk` and the loss-of-signal synchronizer run on `tx_bit_clk`. They keep running when `rx_bit_clk` is stopped.
- R8: With both controls at 1, the deserializer follows R6 and `tx_ser_out` equals `rx_ser_in`.
- R9: The raw loss flag is `~sd_in` when `sd_active_high`=1 and `sd_in` when it is 0. `los` shows the raw flag sampled two receive core clock edges earlier.
- R10: `rst` is synchronous and active high. While it is held, `rx_byte`=0, `rx_byte_valid`=0, `rx_ls_clk`=0, `los`=1, and the serializer bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_bit_clk | input | 1 | Transmit bit clock |
| rx_bit_clk | input | 1 | Receive line bit clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_byte | input | 8 | Parallel byte to transmit |
| rx_ser_in | input | 1 | Serial line receive data |
| fac_loop | input | 1 | Facility loopback enable |
| eq_loop | input | 1 | Equipment loopback enable |
| sd_in | input | 1 | Signal-detect from the optics |
| sd_active_high | input | 1 | 1: sd_in high means signal present |
| tx_ser_out | output | 1 | Serial line transmit data |
| rx_byte | output | 8 | Deserialized receive byte |
| rx_byte_valid | output | 1 | High once the first byte is complete |
| rx_ls_clk | output | 1 | Receive core clock divided by 8 |
| los | output | 1 | Synchronized loss-of-signal flag |

## Verification
The hardest case to reach is equipment loopback with the line clock actually stopped. Only then do the ports show that the receiver runs on the transmit clock and not on a copy of the line clock. The bench builds the line clock by gating the transmit clock and holds the gate closed through the whole equipment and dual runs. It then checks that `rx_ls_clk`, `rx_byte` and `los` keep advancing. The one-bit skew that the loopback register adds is predicted by a bench model of the serial stream. The bench does not assume that bytes stay aligned.

// File: rtl/sds_pkg.sv
package sds_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL    = 2'b00,
        PM_FACILITY  = 2'b01,
        PM_EQUIPMENT = 2'b10,
        PM_DUAL      = 2'b11
    } path_mode_e;

    typedef enum logic {
        SER_LOAD  = 1'b0,
        SER_SHIFT = 1'b1
    } ser_state_e;

    typedef enum logic {
        DES_FILL = 1'b0,
        DES_RUN  = 1'b1
    } des_state_e;

endpackage

// File: rtl/sds_serializer.sv
module sds_serializer
    import sds_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] par_in,
    output logic             ser_out
);
    localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    ser_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [WIDTH-1:0] shreg_q, shreg_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        shreg_d = shreg_q;
        unique case (state_q)
            SER_LOAD: begin
                shreg_d = par_in;
                cnt_d   = CNT_W'(1);
                state_d = SER_SHIFT;
            end
            SER_SHIFT: begin
                shreg_d = {shreg_q[WIDTH-2:0], 1'b0};
                if (cnt_q == LAST) begin
                    cnt_d   = '0;
                    state_d = SER_LOAD;
                end else begin
                    cnt_d   = cnt_q + CNT_W'(1);
                    state_d = SER_SHIFT;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SER_LOAD;
            cnt_q   <= '0;
            shreg_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            shreg_q <= shreg_d;
        end
    end

    always_comb ser_out = shreg_q[WIDTH-1];

    AST_SER_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (state_q == SER_SHIFT && cnt_q == LAST) |=> (state_q == SER_LOAD)); // R1
    AST_SER_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
        (state_q == SER_LOAD) |=> (ser_out == $past(par_in[WIDTH-1]))); // R1

endmodule

// File: rtl/sds_deserializer.sv
module sds_deserializer
    import sds_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_in,
    output logic [WIDTH-1:0] par_out,
    output logic             par_valid,
    output logic             ls_clk
);
    localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(WIDTH / 2);

    des_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [WIDTH-1:0] sh_q, sh_d;
    logic [WIDTH-1:0] out_q, out_d;
    logic             ls_q;

    always_comb begin
        sh_d    = {sh_q[WIDTH-2:0], ser_in};
        cnt_d   = (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
        out_d   = out_q;
        state_d = state_q;
        unique case (state_q)
            DES_FILL: begin
                if (cnt_q == LAST) begin
                    out_d   = sh_d;
                    state_d = DES_RUN;
                end
            end
            DES_RUN: begin
                if (cnt_q == LAST) out_d = sh_d;
                state_d = DES_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DES_FILL;
            cnt_q   <= '0;
            sh_q    <= '0;
            out_q   <= '0;
            ls_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
            out_q   <= out_d;
            ls_q    <= (cnt_d >= HALF);
        end
    end

    always_comb begin
        par_out   = out_q;
        par_valid = (state_q == DES_RUN);
        ls_clk    = ls_q;
    end

    AST_DES_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != LAST) |=> $stable(par_out)); // R3
    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        par_valid |=> par_valid); // R3
    AST_LS_LOW_AT_BYTE: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == LAST) |=> !ls_clk); // R4

endmodule

// File: rtl/sds_los_norm.sv
module sds_los_norm #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sd_in,
    input  logic sd_active_high,
    output logic los
);
    logic             raw_los;
    logic [STAGES-1:0] chain_q;

    always_comb raw_los = sd_active_high ? ~sd_in : sd_in;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[i] <= 1'b1;
            else     chain_q[i] <= (i == 0) ? raw_los : chain_q[(i == 0) ? 0 : i-1];
        end
    end

    always_comb los = chain_q[STAGES-1];

    AST_LOS_FIRST_STAGE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (chain_q[0] == $past(sd_active_high ? ~sd_in : sd_in))); // R9

endmodule

// File: rtl/sds_transceiver.sv
module sds_transceiver
    import sds_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int LOS_STAGES = 2
) (
    input  logic             tx_bit_clk,
    input  logic             rx_bit_clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] tx_byte,
    input  logic             rx_ser_in,
    input  logic             fac_loop,
    input  logic             eq_loop,
    input  logic             sd_in,
    input  logic             sd_active_high,
    output logic             tx_ser_out,
    output logic [WIDTH-1:0] rx_byte,
    output logic             rx_byte_valid,
    output logic             rx_ls_clk,
    output logic             los
);
    path_mode_e mode;
    logic       ser_bit;
    logic       des_din;
    logic       core_clk;

    always_comb begin
        unique case ({eq_loop, fac_loop})
            2'b00: mode = PM_NORMAL;
            2'b01: mode = PM_FACILITY;
            2'b10: mode = PM_EQUIPMENT;
            2'b11: mode = PM_DUAL;
        endcase
    end

    always_comb begin
        unique case (mode)
            PM_NORMAL:    begin des_din = rx_ser_in; tx_ser_out = ser_bit;   end
            PM_FACILITY:  begin des_din = rx_ser_in; tx_ser_out = rx_ser_in; end
            PM_EQUIPMENT: begin des_din = ser_bit;   tx_ser_out = ser_bit;   end
            PM_DUAL:      begin des_din = ser_bit;   tx_ser_out = rx_ser_in; end
        endcase
    end

    assign core_clk = eq_loop ? tx_bit_clk : rx_bit_clk;

    sds_serializer #(.WIDTH(WIDTH)) u_ser (
        .clk     (tx_bit_clk),
        .rst     (rst),
        .par_in  (tx_byte),
        .ser_out (ser_bit)
    );

    sds_deserializer #(.WIDTH(WIDTH)) u_des (
        .clk       (core_clk),
        .rst       (rst),
        .ser_in    (des_din),
        .par_out   (rx_byte),
        .par_valid (rx_byte_valid),
        .ls_clk    (rx_ls_clk)
    );

    sds_los_norm #(.STAGES(LOS_STAGES)) u_los (
        .clk            (core_clk),
        .rst            (rst),
        .sd_in          (sd_in),
        .sd_active_high (sd_active_high),
        .los            (los)
    );

endmodule

// File: tb/tb_sds_transceiver.sv
module tb_sds_transceiver;
    localparam int CLK_PERIOD = 10;
    localparam int NBYTES     = 16;

    logic       clk = 1'b0;
    logic       rx_en = 1'b1;
    logic       rx_clk;
    logic       rst = 1'b1;
    logic [7:0] tx_byte = 8'h00;
    logic       rx_ser_in = 1'b0;
    logic       fac_loop = 1'b0;
    logic       eq_loop = 1'b0;
    logic       sd_in = 1'b0;
    logic       sd_active_high = 1'b1;
    logic       tx_ser_out;
    logic [7:0] rx_byte;
    logic       rx_byte_valid;
    logic       rx_ls_clk;
    logic       los;

    int total = 0;
    int bad   = 0;

    assign rx_clk = clk & rx_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    sds_transceiver dut (
        .tx_bit_clk     (clk),
        .rx_bit_clk     (rx_clk),
        .rst            (rst),
        .tx_byte        (tx_byte),
        .rx_ser_in      (rx_ser_in),
        .fac_loop       (fac_loop),
        .eq_loop        (eq_loop),
        .sd_in          (sd_in),
        .sd_active_high (sd_active_high),
        .tx_ser_out     (tx_ser_out),
        .rx_byte        (rx_byte),
        .rx_byte_valid  (rx_byte_valid),
        .rx_ls_clk      (rx_ls_clk),
        .los            (los)
    );

    function automatic logic [7:0] tbyte(int n, int seed);
        return 8'((n * 37 + 5 + seed * 11) & 255);
    endfunction

    function automatic logic [7:0] rbyte(int n, int seed);
        return 8'((n * 91 + 90 + seed * 23) & 255);
    endfunction

    function automatic logic txbit(int k, int seed);
        logic [7:0] b;
        if (k == 0) return 1'b0;
        b = tbyte((k - 1) / 8, seed);
        return b[7 - ((k - 1) % 8)];
    endfunction

    function automatic logic linebit(int p, int seed);
        logic [7:0] b;
        b = rbyte(p / 8, seed);
        return b[7 - (p % 8)];
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_mode(input logic fac, input logic eq, input logic en, input int seed);
        logic [7:0] hist;
        logic [7:0] exp_byte;
        logic       exp_valid;
        logic       r1, r2, prev_line, line, raw, sd;
        string      tag_rx, tag_ls, tag_tx;
        tag_rx = eq ? "R6" : (fac ? "R5" : "R2");
        tag_ls = eq ? "R7" : "R4";
        tag_tx = fac ? (eq ? "R8" : "R5") : (eq ? "R6" : "R1");
        @(negedge clk);
        fac_loop = fac;
        eq_loop  = eq;
        rx_en    = 1'b1;
        rst      = 1'b1;
        repeat (3) tick();
        check("R10 rx_byte", rx_byte, 8'h00);
        check("R10 valid", {7'd0, rx_byte_valid}, 8'h00);
        check("R10 ls_clk", {7'd0, rx_ls_clk}, 8'h00);
        check("R10 los", {7'd0, los}, 8'h01);
        if (!fac) check("R10 tx_ser_out", {7'd0, tx_ser_out}, 8'h00);
        rx_en = en;
        rst   = 1'b0;
        hist = 8'h00; exp_byte = 8'h00; exp_valid = 1'b0;
        r1 = 1'b1; r2 = 1'b1; prev_line = 1'b0;
        for (int k = 0; k <= 8 * NBYTES; k++) begin
            if (k > 0) begin
                tick();
                hist = {hist[6:0], eq ? txbit(k - 1, seed) : prev_line};
                if (k % 8 == 0) begin
                    exp_byte  = hist;
                    exp_valid = 1'b1;
                end
                check(fac && eq ? "R8 rx_byte" : {tag_rx, " rx_byte"}, rx_byte, exp_byte);
                check("R3 valid", {7'd0, rx_byte_valid}, {7'd0, exp_valid});
                check({tag_ls, " ls_clk"}, {7'd0, rx_ls_clk}, {7'd0, ((k % 8) >= 4)});
                check("R9 los", {7'd0, los}, {7'd0, r2});
            end
            tx_byte        = tbyte(k / 8, seed);
            line           = linebit(k, seed);
            rx_ser_in      = line;
            prev_line      = line;
            sd             = 1'(((k * 5) ^ (k >> 2)) & 1);
            sd_active_high = 1'((k / 16) & 1);
            sd_in          = sd;
            raw            = sd_active_high ? ~sd : sd;
            r2 = r1;
            r1 = raw;
            #1;
            if (k > 0 || fac)
                check({tag_tx, " tx_ser_out"}, {7'd0, tx_ser_out},
                      {7'd0, fac ? line : txbit(k, seed)});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        run_mode(1'b0, 1'b0, 1'b1, 0);
        run_mode(1'b1, 1'b0, 1'b1, 1);
        run_mode(1'b0, 1'b1, 1'b0, 2);
        run_mode(1'b1, 1'b1, 1'b0, 3);
        run_mode(1'b0, 1'b0, 1'b1, 4);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule